// File: doc/BRIEF.md
# LIN Interrupt Source Prioritizer

This block collects the event pulses of a LIN slave controller and keeps one pending flag per source. Of the flags that are pending, it shows only the one with the highest priority on a status code. Software reads that code, services the event and clears the source with a strobe. It then reads the code again, and repeats until the code is zero. An interrupt request line goes high whenever the global enable is set and a nonzero code is shown.

There are eight sources. Six of them use a two-state machine: FLAG_IDLE moves to FLAG_PEND on a set pulse (SET transition). FLAG_PEND moves back to FLAG_IDLE on a clear strobe with no set pulse in the same cycle (CLEAR transition). The two receive-buffer-full sources use a three-state machine instead:
- RX_EMPTY moves to RX_WAIT_RD on a set pulse (ARRIVE).
- RX_WAIT_RD moves to RX_READ_DONE when the first data byte is read and no new set pulse arrives in that cycle (BYTE0_READ).
- RX_READ_DONE moves back to RX_WAIT_RD on a new set pulse (REFILL).
- RX_READ_DONE moves to RX_EMPTY on a clear strobe with no set pulse (RELEASE).

A receive flag therefore cannot be cleared until its buffer has been read. A receive overrun outranks the receive-full source that caused it. That receive-full source stays pending behind the overrun and has to be cleared separately.

Top module: `lin_irq_prioritizer`

## Requirements
- R1: After reset no source is pending: `status_code` is 0 and `irq` is 0. The code 0 never drives `irq` high, whatever `irq_en` is.
- R2: Priority runs from highest to lowest with these codes and `src_clr` bit positions: bus idle 0x04 (bit 0), bit error 0x08 (bit 1), checksum error 0x0C (bit 2), receive overrun 0x14 (bit 3), receive full with checksum OK 0x10 (bit 4), receive full without checksum 0x18 (bit 5), transmit done with checksum 0x1C (bit 6), transmit done without checksum 0x20 (bit 7). `status_code` shows the code of the highest pending source.
- R3: While the overrun and a receive-full source are both pending, the overrun code is shown. After the overrun is cleared, the receive-full code is shown until that source gets its own clear.
- R4: A clear strobe for a receive-full source (bit 4 or 5) takes effect only if a read of the first data byte (`rx_byte0_rd`) occurred in an earlier cycle while the flag was pending. A set pulse after that read requires a new read.
- R5: If a set pulse and the clear strobe of the same source arrive in the same cycle, the flag stays set.
- R6: `irq` equals `irq_en` AND (`status_code` not zero), combinationally, in the same cycle.
- R7: Flags are registered. A set pulse or an accepted clear changes `status_code` right after the next rising clock edge.
- R8: A clear strobe for a source that is not pending has no effect. A set pulse for a source that is already pending leaves it pending.
- R9: A first-byte read strobe while no receive-full flag is pending has no effect, and does not allow a later clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en | input | 1 | Global interrupt enable |
| ev_bus_idle | input | 1 | Set pulse: no bus activity timeout |
| ev_bit_err | input | 1 | Set pulse: bit error |
| ev_cks_err | input | 1 | Set pulse: checksum error |
| ev_rx_ovr | input | 1 | Set pulse: receive overrun |
| ev_rx_cks_ok | input | 1 | Set pulse: receive buffer full, checksum matched |
| ev_rx_grp | input | 1 | Set pulse: receive buffer full, intermediate group |
| ev_tx_cks | input | 1 | Set pulse: transmit done with checksum |
| ev_tx_grp | input | 1 | Set pulse: transmit done, intermediate group |
| rx_byte0_rd | input | 1 | Strobe: first data byte of the buffer read |
| src_clr | input | 8 | Per-source clear strobes, bit order as in R2 |
| status_code | output | STATUS_W | Code of the highest pending source, 0 if none |
| irq | output | 1 | Interrupt request |

## Verification
Two kinds of event can fall in the same cycle. One is a source's set pulse together with its own clear strobe. The other is the first-byte read strobe together with the clear of a receive source. Directed steps drive both pairs on one clock edge, and they also come up many times in a long random run with sparse pulses. A behavioural reference model in the bench judges each of these cycles: the set pulse must win, and a read in the same cycle must not allow the clear. The model also covers an overrun that arrives on top of a pending receive-full flag, and checks what shows through after the overrun is cleared.

// File: rtl/lin_irq_pkg.sv
package lin_irq_pkg;

    localparam int NSRC       = 8;
    localparam int CODE_BITS  = 8;

    // Source index equals priority rank (0 = highest)
    localparam int IDX_BUS_IDLE = 0;
    localparam int IDX_BIT_ERR  = 1;
    localparam int IDX_CKS_ERR  = 2;
    localparam int IDX_RX_OVR   = 3;
    localparam int IDX_RX_OK    = 4;
    localparam int IDX_RX_GRP   = 5;
    localparam int IDX_TX_CKS   = 6;
    localparam int IDX_TX_GRP   = 7;

    typedef enum logic [0:0] {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_e;

    typedef enum logic [1:0] {
        RX_EMPTY     = 2'd0,
        RX_WAIT_RD   = 2'd1,
        RX_READ_DONE = 2'd2
    } rxg_state_e;

    function automatic logic [CODE_BITS-1:0] src_code(input int idx);
        logic [CODE_BITS-1:0] c;
        case (idx)
            IDX_BUS_IDLE: c = 8'h04;
            IDX_BIT_ERR:  c = 8'h08;
            IDX_CKS_ERR:  c = 8'h0C;
            IDX_RX_OVR:   c = 8'h14;
            IDX_RX_OK:    c = 8'h10;
            IDX_RX_GRP:   c = 8'h18;
            IDX_TX_CKS:   c = 8'h1C;
            IDX_TX_GRP:   c = 8'h20;
            default:      c = 8'h00;
        endcase
        return c;
    endfunction

    function automatic bit src_is_rx(input int idx);
        return (idx == IDX_RX_OK) || (idx == IDX_RX_GRP);
    endfunction

endpackage

// File: rtl/lin_irq_flag.sv
module lin_irq_flag
    import lin_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    flag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (set_i)           state_d = FLAG_PEND;
            FLAG_PEND: if (clr_i && !set_i) state_d = FLAG_IDLE;
            default:                        state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FLAG_PEND: pend_o = 1'b1;
            default:   pend_o = 1'b0;
        endcase
    end

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(pend_o));

endmodule

// File: rtl/lin_irq_rxgate.sv
module lin_irq_rxgate
    import lin_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic clr_i,
    output logic pend_o
);

    rxg_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY:     if (set_i)          state_d = RX_WAIT_RD;
            RX_WAIT_RD:   if (!set_i && rd_i) state_d = RX_READ_DONE;
            RX_READ_DONE: begin
                if (set_i)      state_d = RX_WAIT_RD;
                else if (clr_i) state_d = RX_EMPTY;
            end
            default:                          state_d = RX_EMPTY;
        endcase
    end

    always_comb begin
        unique case (state_q)
            RX_WAIT_RD, RX_READ_DONE: pend_o = 1'b1;
            default:                  pend_o = 1'b0;
        endcase
    end

    // R4
    rx_unread_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && state_q != RX_READ_DONE) |=> pend_o);

    // R4
    rx_release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_o) |-> ($past(clr_i) && !$past(set_i)));

    // R5
    rx_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);

endmodule

// File: rtl/lin_irq_encoder.sv
module lin_irq_encoder
    import lin_irq_pkg::*;
#(
    parameter int N        = NSRC,
    parameter int STATUS_W = CODE_BITS
) (
    input  logic [N-1:0]        pend_i,
    output logic [N-1:0]        grant_o,
    output logic [STATUS_W-1:0] code_o
);

    logic found;

    always_comb begin
        grant_o = '0;
        found   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (pend_i[i] && !found) begin
                grant_o[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    always_comb begin
        code_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_o[i]) code_o = STATUS_W'(src_code(i));
        end
    end

endmodule

// File: rtl/lin_irq_prioritizer.sv
module lin_irq_prioritizer
    import lin_irq_pkg::*;
#(
    parameter int STATUS_W = CODE_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_en,
    input  logic                ev_bus_idle,
    input  logic                ev_bit_err,
    input  logic                ev_cks_err,
    input  logic                ev_rx_ovr,
    input  logic                ev_rx_cks_ok,
    input  logic                ev_rx_grp,
    input  logic                ev_tx_cks,
    input  logic                ev_tx_grp,
    input  logic                rx_byte0_rd,
    input  logic [NSRC-1:0]     src_clr,
    output logic [STATUS_W-1:0] status_code,
    output logic                irq
);

    localparam logic [STATUS_W-1:0] CODE_RX_OK  = STATUS_W'(src_code(IDX_RX_OK));
    localparam logic [STATUS_W-1:0] CODE_RX_GRP = STATUS_W'(src_code(IDX_RX_GRP));

    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] pend_vec;
    logic [NSRC-1:0] grant_vec;

    always_comb begin
        set_vec               = '0;
        set_vec[IDX_BUS_IDLE] = ev_bus_idle;
        set_vec[IDX_BIT_ERR]  = ev_bit_err;
        set_vec[IDX_CKS_ERR]  = ev_cks_err;
        set_vec[IDX_RX_OVR]   = ev_rx_ovr;
        set_vec[IDX_RX_OK]    = ev_rx_cks_ok;
        set_vec[IDX_RX_GRP]   = ev_rx_grp;
        set_vec[IDX_TX_CKS]   = ev_tx_cks;
        set_vec[IDX_TX_GRP]   = ev_tx_grp;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        if (src_is_rx(g)) begin : g_rx
            lin_irq_rxgate u_gate (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_vec[g]),
                .rd_i   (rx_byte0_rd),
                .clr_i  (src_clr[g]),
                .pend_o (pend_vec[g])
            );
        end else begin : g_plain
            lin_irq_flag u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_vec[g]),
                .clr_i  (src_clr[g]),
                .pend_o (pend_vec[g])
            );
        end
    end

    lin_irq_encoder #(
        .N        (NSRC),
        .STATUS_W (STATUS_W)
    ) u_enc (
        .pend_i  (pend_vec),
        .grant_o (grant_vec),
        .code_o  (status_code)
    );

    assign irq = irq_en && (status_code != '0);

    // R1
    zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec == '0) |-> (!irq && status_code == '0));

    // R2
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec) && ((grant_vec != '0) == (pend_vec != '0)));

    // R3
    ovr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vec[IDX_RX_OVR] |-> (status_code != CODE_RX_OK && status_code != CODE_RX_GRP));

    // R6
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

endmodule

// File: tb/lin_irq_prioritizer_test.sv
module lin_irq_prioritizer_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] ev = '0;
    logic       rd = 1'b0;
    logic [7:0] clr = '0;
    logic [7:0] status_code;
    logic       irq;

    int tests = 0;
    int fails = 0;
    string tag = "R1";

    // model state
    bit mpend [8];
    int rxs [2];              // 0 empty, 1 waiting for read, 2 read seen
    int codes [8] = '{4, 8, 12, 20, 16, 24, 28, 32};

    always #2.5 clk = ~clk;

    lin_irq_prioritizer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_en       (irq_en),
        .ev_bus_idle  (ev[0]),
        .ev_bit_err   (ev[1]),
        .ev_cks_err   (ev[2]),
        .ev_rx_ovr    (ev[3]),
        .ev_rx_cks_ok (ev[4]),
        .ev_rx_grp    (ev[5]),
        .ev_tx_cks    (ev[6]),
        .ev_tx_grp    (ev[7]),
        .rx_byte0_rd  (rd),
        .src_clr      (clr),
        .status_code  (status_code),
        .irq          (irq)
    );

    task automatic model_update();
        if (!rst_n) begin
            foreach (mpend[i]) mpend[i] = 1'b0;
            rxs[0] = 0;
            rxs[1] = 0;
            return;
        end
        for (int i = 0; i < 8; i++) begin
            if (i == 4 || i == 5) begin
                int k = i - 4;
                case (rxs[k])
                    0: if (ev[i]) rxs[k] = 1;
                    1: if (!ev[i] && rd) rxs[k] = 2;
                    default: begin
                        if (ev[i]) rxs[k] = 1;
                        else if (clr[i]) rxs[k] = 0;
                    end
                endcase
                mpend[i] = (rxs[k] != 0);
            end else begin
                mpend[i] = ev[i] | (mpend[i] & ~clr[i]);
            end
        end
    endtask

    function automatic int exp_code();
        for (int i = 0; i < 8; i++) if (mpend[i]) return codes[i];
        return 0;
    endfunction

    task automatic compare();
        int ec = exp_code();
        bit ei = irq_en && (ec != 0);
        tests++;
        if (int'(status_code) != ec) begin
            fails++;
            $display("FAIL %s status_code actual=%h expected=%h", tag, status_code, ec);
        end
        tests++;
        if (irq !== ei) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, ei);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
        ev  = '0;
        clr = '0;
        rd  = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        tag = "R1";
        irq_en = 1'b1;
        @(negedge clk);
        tick();
        tick();
        rst_n = 1'b1;
        tick();

        // R2: all sources pending, cleared one at a time in rank order
        tag = "R2";
        ev = 8'hFF; tick();
        for (int i = 0; i < 4; i++) begin clr[i] = 1'b1; tick(); end
        rd = 1'b1; tick();
        for (int i = 4; i < 8; i++) begin clr[i] = 1'b1; tick(); end

        // R3: overrun on top of a pending receive-full source
        tag = "R3";
        ev[4] = 1'b1; tick();
        ev[3] = 1'b1; tick();
        clr[3] = 1'b1; tick();
        // R4: clear without a prior read is refused
        tag = "R4";
        clr[4] = 1'b1; tick();
        rd = 1'b1; tick();
        clr[4] = 1'b1; tick();

        // R4: set after read needs a fresh read; read and clear together refused
        ev[5] = 1'b1; tick();
        rd = 1'b1; tick();
        ev[5] = 1'b1; tick();
        clr[5] = 1'b1; tick();
        rd = 1'b1; clr[5] = 1'b1; tick();
        clr[5] = 1'b1; tick();

        // R9: read with nothing pending does not allow a later clear
        tag = "R9";
        rd = 1'b1; tick();
        ev[5] = 1'b1; tick();
        clr[5] = 1'b1; tick();
        rd = 1'b1; tick();
        clr[5] = 1'b1; tick();

        // R5: set and clear of the same source in one cycle
        tag = "R5";
        ev[6] = 1'b1; clr[6] = 1'b1; tick();
        ev[6] = 1'b1; clr[6] = 1'b1; tick();
        clr[6] = 1'b1; tick();

        // R8: clears of idle sources, repeated set of a pending one
        tag = "R8";
        ev[7] = 1'b1; tick();
        clr = 8'h7F; tick();
        ev[7] = 1'b1; tick();
        clr[7] = 1'b1; tick();

        // R6: enable gating
        tag = "R6";
        ev[2] = 1'b1; irq_en = 1'b0; tick();
        irq_en = 1'b1; tick();
        irq_en = 1'b0; clr[2] = 1'b1; tick();
        irq_en = 1'b1; tick();

        // R7: one-edge latency checked every cycle; random mix covers R2 and R6 too
        tag = "R7";
        for (int n = 0; n < 4000; n++) begin
            for (int b = 0; b < 8; b++) begin
                ev[b]  = ($urandom % 9) == 0;
                clr[b] = ($urandom % 3) == 0;
            end
            rd     = ($urandom % 4) == 0;
            irq_en = ($urandom % 5) != 0;
            tick();
        end

        finish_run();
    end

endmodule